// File: doc/BRIEF.md
# Variable-length instruction aligner

The aligner sits between an instruction fetch unit and a decoder. Fetch delivers 32-bit words, each carrying two 16-bit parcels (lower address in bits [15:0]), in ascending address order. The aligner reads the low bits of the first parcel of each instruction to learn how many parcels it occupies. It keeps parcels in a shift-down parcel buffer until the whole instruction is present, then presents it right-aligned in a 64-bit word, with a two-bit size code and its byte address. Both sides use valid/ready handshakes. Instructions may begin on any halfword and may straddle fetch words.

A redirect (flush) empties the buffer and loads the next instruction address from the flush target. A small state machine governs the lower half of the next accepted word. In state `ST_PAIR`, both parcels of the next accepted word are kept. In state `ST_DROP_LO`, the lower parcel of the next accepted word is discarded. The transitions are as follows:

- `ST_PAIR` goes to `ST_DROP_LO` on a flush whose target has address bit 1 set.
- `ST_DROP_LO` goes back to `ST_PAIR` when a word is accepted, or on a flush whose target has bit 1 clear.
- `ST_DROP_LO` stays in `ST_DROP_LO` on a flush whose target has bit 1 set.
- Every other cycle keeps the current state.

Top module: `insn_aligner`

## Requirements
- R1: A first parcel whose bits [1:0] are 00, 01 or 10 is emitted as a one-parcel instruction with size code 0 and only that parcel consumed.
- R2: A first parcel with bits [1:0]=11 and bits [4:2] not 111 is emitted as a two-parcel instruction with size code 1.
- R3: A first parcel with bits [5:0]=011111 is emitted as a three-parcel instruction with size code 2.
- R4: A first parcel with bits [6:0]=0111111 is emitted as a four-parcel instruction with size code 3, including one starting in the upper half of a fetch word.
- R5: A first parcel with bits [6:0]=1111111 is emitted alone, with the illegal flag set and size code 0.
- R6: Output bits above the instruction's size are zero; the first parcel sits in bits [15:0], and each later parcel occupies the next 16 bits.
- R7: Each emitted address equals the previous emitted address plus 2, 4, 6 or 8 bytes for the previous instruction's size.
- R8: Output valid is high exactly when the buffer holds every parcel of the oldest pending instruction and no flush is present.
- R9: A flush empties the buffer, drops output valid, and makes the next emitted address the target. If target bit 1 is set, the lower parcel of the first word accepted afterwards is discarded.
- R10: Input ready is high exactly when no flush is present and at most BUF_DEPTH-2 parcels are buffered; the buffer never exceeds BUF_DEPTH parcels.
- R11: While output valid is high and output ready is low, the output word and address hold until accepted or flushed.
- R12: After reset, output valid is low, input ready is high, the output address is 0 and the state is `ST_PAIR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Redirect: empty the buffer and restart at flush_addr_i |
| flush_addr_i | input | ADDR_W | Even byte address of the redirect target |
| in_valid_i | input | 1 | Fetch word present |
| in_ready_o | output | 1 | Aligner accepts the fetch word this cycle |
| in_word_i | input | 32 | Fetch word; bits [15:0] are the lower-address parcel |
| out_valid_o | output | 1 | Complete instruction present |
| out_ready_i | input | 1 | Consumer takes the instruction this cycle |
| out_insn_o | output | 64 | Instruction, right-aligned, upper bits zero |
| out_len_o | output | 2 | Size code: 0=16, 1=32, 2=48, 3=64 bits |
| out_illegal_o | output | 1 | First parcel carries a reserved length pattern |
| out_addr_o | output | ADDR_W | Byte address of the instruction |

## Verification
The hardest case to reach is a full buffer while a 64-bit instruction starts on an odd halfword. That case needs the consumer held off long enough for the fill to cross the ready threshold, with the long instruction's last parcel arriving in the word that is then refused. The stimulus holds output ready low for the first 25 cycles of a program made only of 64-bit instructions, placed at a target with bit 1 set. A second hard case is a flush that lands while a partial instruction is buffered. The bench redirects mid-program and expects the stale parcels to vanish with no output.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
    localparam int PARCEL_W = 16;

    typedef enum logic [1:0] {
        LEN16 = 2'd0,
        LEN32 = 2'd1,
        LEN48 = 2'd2,
        LEN64 = 2'd3
    } ilen_e;

    typedef enum logic {
        ST_PAIR    = 1'b0,
        ST_DROP_LO = 1'b1
    } fstate_e;
endpackage

// File: rtl/len_decode.sv
module len_decode
    import aligner_pkg::*;
(
    input  logic [6:0] low7_i,
    output ilen_e      len_o,
    output logic       illegal_o,
    output logic [2:0] parcels_o
);
    always_comb begin
        illegal_o = 1'b0;
        if (low7_i[1:0] != 2'b11) begin
            len_o = LEN16;
        end else if (low7_i[4:2] != 3'b111) begin
            len_o = LEN32;
        end else if (!low7_i[5]) begin
            len_o = LEN48;
        end else if (!low7_i[6]) begin
            len_o = LEN64;
        end else begin
            len_o     = LEN16;
            illegal_o = 1'b1;
        end
        parcels_o = {1'b0, len_o} + 3'd1;
    end
endmodule

// File: rtl/parcel_buf.sv
module parcel_buf #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic [1:0]                   push_cnt_i,
    input  logic [15:0]                  push_p0_i,
    input  logic [15:0]                  push_p1_i,
    input  logic [2:0]                   pop_cnt_i,
    output logic [63:0]                  head_o,
    output logic [$clog2(DEPTH+1)-1:0]   fill_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);
    localparam int HEAD_N = 4;

    logic [15:0]   mem_q [DEPTH];
    logic [15:0]   mem_d [DEPTH];
    logic [CW-1:0] cnt_q, cnt_d, kept;

    always_comb begin
        logic [31:0] src;
        logic [31:0] dst;
        kept = cnt_q - CW'(pop_cnt_i);
        for (int i = 0; i < DEPTH; i++) begin
            src = 32'(i) + 32'(pop_cnt_i);
            if (src < 32'(DEPTH)) mem_d[i] = mem_q[src[IW-1:0]];
            else                  mem_d[i] = '0;
        end
        for (int k = 0; k < 2; k++) begin
            dst = 32'(kept) + 32'(k);
            if (k < int'(push_cnt_i) && dst < 32'(DEPTH))
                mem_d[dst[IW-1:0]] = (k == 0) ? push_p0_i : push_p1_i;
        end
        cnt_d = kept + CW'(push_cnt_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < HEAD_N; g++) begin : g_head
        assign head_o[16*g +: 16] = mem_q[g];
    end
    assign fill_o = cnt_q;

    // R10: pushes never run past the buffer's capacity
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (32'(cnt_q) - 32'(pop_cnt_i) + 32'(push_cnt_i) <= 32'(DEPTH)));

    // R8: an instruction is never taken before all its parcels are present
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pop_cnt_i) <= 32'(cnt_q));
endmodule

// File: rtl/insn_aligner.sv
module insn_aligner
    import aligner_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [31:0]       in_word_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [63:0]       out_insn_o,
    output logic [1:0]        out_len_o,
    output logic              out_illegal_o,
    output logic [ADDR_W-1:0] out_addr_o
);
    localparam int CW = $clog2(BUF_DEPTH + 1);

    fstate_e           st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [63:0]       head;
    logic [CW-1:0]     fill;
    ilen_e             len;
    logic              illegal;
    logic [2:0]        parcels;
    logic              fire_in, fire_out;
    logic [1:0]        push_cnt;
    logic [15:0]       push_p0;
    logic [2:0]        pop_cnt;
    logic [ADDR_W-1:0] step_bytes;

    len_decode u_dec (
        .low7_i    (head[6:0]),
        .len_o     (len),
        .illegal_o (illegal),
        .parcels_o (parcels)
    );

    parcel_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (flush_i),
        .push_cnt_i (push_cnt),
        .push_p0_i  (push_p0),
        .push_p1_i  (in_word_i[31:16]),
        .pop_cnt_i  (pop_cnt),
        .head_o     (head),
        .fill_o     (fill)
    );

    // handshakes
    assign in_ready_o  = !flush_i && (int'(fill) <= BUF_DEPTH - 2);
    assign out_valid_o = !flush_i && (int'(fill) >= int'(parcels));
    assign fire_in     = in_valid_i && in_ready_o;
    assign fire_out    = out_valid_o && out_ready_i;
    assign pop_cnt     = fire_out ? parcels : 3'd0;
    assign step_bytes  = ADDR_W'({1'b0, len} + 3'd1) << 1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_PAIR;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PAIR: begin
                if (flush_i && flush_addr_i[1]) st_d = ST_DROP_LO;
            end
            ST_DROP_LO: begin
                if (flush_i)      st_d = flush_addr_i[1] ? ST_DROP_LO : ST_PAIR;
                else if (fire_in) st_d = ST_PAIR;
            end
        endcase
    end

    // outputs of the state machine: what enters the buffer
    always_comb begin
        push_cnt = 2'd0;
        push_p0  = in_word_i[15:0];
        unique case (st_q)
            ST_PAIR: begin
                if (fire_in) push_cnt = 2'd2;
            end
            ST_DROP_LO: begin
                push_p0 = in_word_i[31:16];
                if (fire_in) push_cnt = 2'd1;
            end
        endcase
    end

    // address tracking
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (flush_i)  addr_q <= {flush_addr_i[ADDR_W-1:1], 1'b0};
        else if (fire_out) addr_q <= addr_q + step_bytes;
    end

    // output word, masked to the instruction size
    always_comb begin
        unique case (len)
            LEN16: out_insn_o = {48'd0, head[15:0]};
            LEN32: out_insn_o = {32'd0, head[31:0]};
            LEN48: out_insn_o = {16'd0, head[47:0]};
            LEN64: out_insn_o = head;
        endcase
    end
    assign out_len_o     = len;
    assign out_illegal_o = illegal;
    assign out_addr_o    = addr_q;

    // R11: a stalled output stays put
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !flush_i) |=>
            (flush_i || (out_valid_o && $stable(out_insn_o) && $stable(out_addr_o))));

    // R7: address advances by the size just emitted
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_out && !flush_i) |=> out_addr_o == $past(out_addr_o) + $past(step_bytes));

    // R9: a flush leaves nothing to emit on the next cycle
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !out_valid_o);

    // R5: a reserved pattern is always a single parcel
    p_illegal_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal_o |-> out_len_o == 2'd0);

    // R6: nothing above the instruction size
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_len_o == 2'd0) |-> out_insn_o[63:16] == 48'd0);
endmodule

// File: tb/sim_insn_aligner.sv
module sim_insn_aligner;
    localparam int AW    = 32;
    localparam int DEPTH = 8;
    localparam int NPAR  = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic [AW-1:0] flush_addr_i = '0;
    logic          in_valid_i = 1'b0;
    logic          in_ready_o;
    logic [31:0]   in_word_i = '0;
    logic          out_valid_o;
    logic          out_ready_i = 1'b0;
    logic [63:0]   out_insn_o;
    logic [1:0]    out_len_o;
    logic          out_illegal_o;
    logic [AW-1:0] out_addr_o;

    always #10 clk = ~clk;

    insn_aligner #(.ADDR_W(AW), .BUF_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_word_i(in_word_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_insn_o(out_insn_o),
        .out_len_o(out_len_o), .out_illegal_o(out_illegal_o), .out_addr_o(out_addr_o)
    );

    typedef struct {
        logic [63:0]   data;
        int            np;
        logic [1:0]    len;
        bit            ill;
        logic [AW-1:0] addr;
    } exp_t;

    exp_t          expq[$];
    logic [15:0]   rq[$];
    logic [15:0]   pmem [NPAR];
    int            errors = 0;
    int            checks = 0;
    int            fetch_w = 0;
    int            fetch_end = 0;
    int            rmode = 0;
    int            cyc = 0;
    bit            skip = 0;
    bit            flush_req = 0;
    bit            first = 1;
    bit            hold_prev = 0;
    logic [63:0]   held_insn;
    logic [AW-1:0] held_addr;
    logic [AW-1:0] flush_tgt = '0;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] first_parcel(int kind);
        logic [15:0] r;
        r = 16'($urandom);
        case (kind)
            0: r[1:0] = 2'($urandom_range(0, 2));
            1: begin
                r[1:0] = 2'b11;
                if (r[4:2] == 3'b111) r[4:2] = 3'b010;
            end
            2: r[5:0] = 6'b011111;
            3: r[6:0] = 7'b0111111;
            default: r[6:0] = 7'b1111111;
        endcase
        return r;
    endfunction

    task automatic add_insn(inout int p, input int kind);
        exp_t e;
        logic [15:0] par;
        e.np   = (kind == 4) ? 1 : kind + 1;
        e.len  = (kind == 4) ? 2'd0 : 2'(kind);
        e.ill  = (kind == 4);
        e.addr = AW'(p * 2);
        e.data = '0;
        for (int j = 0; j < e.np; j++) begin
            par = (j == 0) ? first_parcel(kind) : 16'($urandom);
            pmem[p + j] = par;
            e.data[16*j +: 16] = par;
        end
        p += e.np;
        expq.push_back(e);
    endtask

    // pattern 0: mixed legal sizes, 1: all 64-bit, 2: mixed with reserved patterns
    task automatic load_program(int base, int n, int pattern, bit do_flush);
        int p;
        int kind;
        p = base / 2;
        expq.delete();
        if (p % 2 == 1) pmem[p - 1] = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            kind = (pattern == 0) ? int'($urandom_range(0, 3)) :
                   (pattern == 1) ? 3 : int'($urandom_range(0, 4));
            add_insn(p, kind);
        end
        if (p % 2 == 1) add_insn(p, 0);
        fetch_w   = base / 4;
        fetch_end = p / 2;
        cyc       = 0;
        if (do_flush) begin
            flush_req = 1'b1;
            flush_tgt = AW'(base);
        end
    endtask

    task automatic step();
        int    np;
        bit    ev;
        bit    er;
        string tg;
        @(negedge clk);
        cyc++;
        flush_i      = flush_req;
        flush_addr_i = flush_tgt;
        in_valid_i   = !flush_req && (fetch_w < fetch_end) &&
                       (rmode != 1 || $urandom_range(0, 3) != 0);
        in_word_i    = (fetch_w < fetch_end) ? {pmem[2*fetch_w+1], pmem[2*fetch_w]} : 32'd0;
        out_ready_i  = (rmode == 0) ? 1'b1 :
                       (rmode == 1) ? ($urandom_range(0, 2) != 0) : (cyc > 25);
        #1;
        er = !flush_req && (rq.size() <= DEPTH - 2);
        chk(in_ready_o == er, "R10", "in_ready", 64'(in_ready_o), 64'(er));
        np = (expq.size() > 0) ? expq[0].np : 99;
        ev = !flush_req && (expq.size() > 0) && (rq.size() >= np);
        chk(out_valid_o == ev, flush_req ? "R9" : "R8", "out_valid", 64'(out_valid_o), 64'(ev));
        if (hold_prev && out_valid_o) begin
            chk(out_insn_o == held_insn, "R11", "held insn", out_insn_o, held_insn);
            chk(out_addr_o == held_addr, "R11", "held addr", 64'(out_addr_o), 64'(held_addr));
        end
        if (ev && out_valid_o) begin
            tg = expq[0].ill ? "R5" :
                 (expq[0].len == 2'd0) ? "R1" : (expq[0].len == 2'd1) ? "R2" :
                 (expq[0].len == 2'd2) ? "R3" : "R4";
            chk(out_insn_o == expq[0].data, tg, "insn", out_insn_o, expq[0].data);
            chk(out_len_o == expq[0].len, tg, "len code", 64'(out_len_o), 64'(expq[0].len));
            chk(out_illegal_o == expq[0].ill, "R5", "illegal flag", 64'(out_illegal_o), 64'(expq[0].ill));
            chk(out_addr_o == expq[0].addr, first ? "R9" : "R7", "addr",
                64'(out_addr_o), 64'(expq[0].addr));
            chk((out_insn_o >> (16 * expq[0].np)) == 64'd0, "R6", "upper bits",
                out_insn_o >> (16 * expq[0].np), 64'd0);
        end
        hold_prev = out_valid_o && !out_ready_i && !flush_req;
        held_insn = out_insn_o;
        held_addr = out_addr_o;
        if (flush_req) begin
            rq.delete();
            skip      = flush_tgt[1];
            flush_req = 1'b0;
            first     = 1'b1;
        end else begin
            if (ev && out_valid_o && out_ready_i) begin
                repeat (np) void'(rq.pop_front());
                void'(expq.pop_front());
                first = 1'b0;
            end
            if (in_valid_i && in_ready_o) begin
                if (!skip) rq.push_back(in_word_i[15:0]);
                rq.push_back(in_word_i[31:16]);
                skip = 1'b0;
                fetch_w++;
            end
        end
    endtask

    task automatic run_until_done();
        int guard;
        guard = 0;
        while ((expq.size() > 0 || fetch_w < fetch_end || flush_req) && guard < 4000) begin
            step();
            guard++;
        end
        chk(expq.size() == 0, "R8", "program drained", 64'(expq.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPAR; i++) pmem[i] = 16'h0001;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid_o == 1'b0, "R12", "out_valid in reset", 64'(out_valid_o), 64'd0);
        chk(in_ready_o == 1'b1, "R12", "in_ready in reset", 64'(in_ready_o), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_addr_o == '0, "R12", "addr after reset", 64'(out_addr_o), 64'd0);
        chk(out_valid_o == 1'b0, "R12", "out_valid after reset", 64'(out_valid_o), 64'd0);

        rmode = 0;
        load_program(0, 30, 0, 1'b0);
        run_until_done();

        rmode = 1;
        load_program(32'h102, 30, 2, 1'b1);
        run_until_done();

        // R4 R10: 64-bit instructions from an odd halfword, consumer held off
        rmode = 2;
        load_program(32'h206, 25, 1, 1'b1);
        run_until_done();

        // R9: redirect while partial instructions sit in the buffer
        rmode = 0;
        load_program(32'h30A, 30, 0, 1'b1);
        repeat (15) step();
        rmode = 1;
        load_program(32'h40E, 20, 2, 1'b1);
        run_until_done();

        rmode = 1;
        load_program(32'h512, 20, 1, 1'b1);
        run_until_done();

        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule